// File: doc/BRIEF.md
# Flash Embedded Operation Status Responder

This block drives the read data bus of a parallel NOR flash while an internal program or erase runs. A one-cycle start pulse marks the final write strobe of a program or erase command. The pulse carries the operation type and, for program, the target byte. From then until the operation finishes, reads return status instead of array contents. Bit 7 gives a polarity flag and bit 6 flips on each read, so host software can poll for completion.

Two parameterised cycle counts stand in for the internal program and erase times. After either one ends, a settle window follows, also a cycle-count parameter. During that window bit 7 already carries its final value, but the lower bits are not yet trustworthy. After the window the block passes the array data straight through. A read whose address is outside the valid range yields no status at all.

Top module: `flash_stat_resp`

## Requirements
- R1: After a synchronous reset, busy_o is 0 and a read with a valid address returns array_data_i unchanged.
- R2: A start pulse accepted while not busy raises busy_o from the next cycle. busy_o then stays high for exactly PROG_CYCLES cycles for a program (op_erase_i = 0) or ERASE_CYCLES cycles for an erase (op_erase_i = 1).
- R3: A start pulse that arrives while busy_o is high is ignored. The operation type, target byte and remaining duration all stay as they were.
- R4: While a program is busy, bit 7 of rd_data_o is the inverse of bit 7 of the byte being programmed.
- R5: While an erase is busy, bit 7 of rd_data_o is 0.
- R6: While busy, bit 6 of rd_data_o starts at 0 when the operation is accepted. It inverts once for each falling edge of rd_strobe_i that is seen on a clock edge while busy, and the change is visible from the following cycle. Bits 5 to 0 read as all ones.
- R7: A falling edge of rd_strobe_i that is sampled while addr_valid_i is 0 does not change the bit 6 toggle state.
- R8: For SETTLE_CYCLES cycles after busy_o falls, bit 7 of rd_data_o holds its final value: the programmed byte's bit 7 for a program, or 1 for an erase. Bits 6 to 0 read as all ones.
- R9: Once the settle window ends, rd_data_o equals array_data_i.
- R10: Whenever addr_valid_i is 0, rd_data_o is 8'h00 in every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that starts an internal operation |
| op_erase_i | input | 1 | Operation type with start_i: 0 program, 1 erase |
| prog_byte_i | input | 8 | Byte being programmed, captured with start_i |
| array_data_i | input | 8 | Data read from the array |
| rd_strobe_i | input | 1 | Read strobe; its falling edge advances the toggle bit |
| addr_valid_i | input | 1 | High when the read address is in the valid range |
| rd_data_o | output | 8 | Read data bus |
| busy_o | output | 1 | High while the internal operation runs |

## Verification
Every one of the 256 program target bytes is tried, which shows that bit 7 really tracks the inverted target bit. The remaining bits of the byte are shown to follow the fixed fill patterns. A set of erase runs shows that bit 7 is 0 while busy and 1 afterwards, whatever byte arrives with the start.

Four read-strobe patterns are cycled across the runs: a strobe every cycle, a strobe every other cycle, a strobe held high, and a strobe mixed with invalid-address cycles. These separate a toggle that follows strobe falls from one that follows the clock or the strobe level. They also show that falls seen with an invalid address have no effect. Restart pulses in the middle of an operation show that the first operation's type, byte and length survive.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_BUSY   = 2'd1,
        PH_SETTLE = 2'd2
    } phase_e;

    typedef struct packed {
        logic          erase;
        logic [DW-1:0] target;
    } op_t;

    localparam logic [DW-3:0] BUSY_FILL   = '1;
    localparam logic [DW-2:0] SETTLE_FILL = '1;

    function automatic logic [DW-1:0] busy_word(input op_t op, input logic tog);
        logic flag;
        flag = op.erase ? 1'b0 : ~op.target[DW-1];
        return {flag, tog, BUSY_FILL};
    endfunction

    function automatic logic [DW-1:0] settle_word(input op_t op);
        logic flag;
        flag = op.erase ? 1'b1 : op.target[DW-1];
        return {flag, SETTLE_FILL};
    endfunction

endpackage

// File: rtl/flash_stat_seq.sv
module flash_stat_seq
    import flash_stat_pkg::*;
#(
    parameter int PROG_CYCLES   = 20,
    parameter int ERASE_CYCLES  = 60,
    parameter int SETTLE_CYCLES = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          erase_i,
    input  logic [DW-1:0] target_i,
    output phase_e        phase_o,
    output op_t           op_o,
    output logic          accept_o
);
    localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES)
                        ? ((PROG_CYCLES > SETTLE_CYCLES) ? PROG_CYCLES : SETTLE_CYCLES)
                        : ((ERASE_CYCLES > SETTLE_CYCLES) ? ERASE_CYCLES : SETTLE_CYCLES);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] P_LOAD = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] E_LOAD = CW'(ERASE_CYCLES - 1);
    localparam logic [CW-1:0] S_LOAD = CW'(SETTLE_CYCLES - 1);

    phase_e        phase_q;
    op_t           op_q;
    logic [CW-1:0] cnt_q;
    logic          accept;

    assign accept = start_i && (phase_q != PH_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            op_q    <= '0;
            cnt_q   <= '0;
        end else if (accept) begin
            phase_q   <= PH_BUSY;
            op_q.erase  <= erase_i;
            op_q.target <= target_i;
            cnt_q     <= erase_i ? E_LOAD : P_LOAD;
        end else begin
            case (phase_q)
                PH_BUSY: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_SETTLE;
                        cnt_q   <= S_LOAD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_SETTLE: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign phase_o  = phase_q;
    assign op_o     = op_q;
    assign accept_o = accept;

    // R2
    busy_countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BUSY && cnt_q != '0) |=>
        (phase_q == PH_BUSY && cnt_q == $past(cnt_q) - 1'b1));

    // R3
    op_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BUSY) |=> $stable(op_q));

    // R8
    settle_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BUSY && cnt_q == '0) |=> (phase_q == PH_SETTLE));

endmodule

// File: rtl/flash_stat_toggle.sv
module flash_stat_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic busy_i,
    input  logic strobe_i,
    input  logic valid_i,
    output logic tog_o
);
    logic strobe_q;
    logic tog_q;
    logic fall;

    assign fall = strobe_q && !strobe_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            tog_q    <= 1'b0;
        end else begin
            strobe_q <= strobe_i;
            if (clear_i) begin
                tog_q <= 1'b0;
            end else if (fall && busy_i && valid_i) begin
                tog_q <= ~tog_q;
            end
        end
    end

    assign tog_o = tog_q;

    // R7
    invalid_no_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && !clear_i) |=> $stable(tog_q));

    // R6
    toggle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !tog_q);

endmodule

// File: rtl/flash_stat_mux.sv
module flash_stat_mux
    import flash_stat_pkg::*;
(
    input  phase_e        phase_i,
    input  op_t           op_i,
    input  logic          tog_i,
    input  logic          valid_i,
    input  logic [DW-1:0] array_i,
    output logic [DW-1:0] data_o
);
    always_comb begin
        if (!valid_i) begin
            data_o = '0;
        end else begin
            case (phase_i)
                PH_BUSY:   data_o = busy_word(op_i, tog_i);
                PH_SETTLE: data_o = settle_word(op_i);
                default:   data_o = array_i;
            endcase
        end
    end
endmodule

// File: rtl/flash_stat_resp.sv
module flash_stat_resp
    import flash_stat_pkg::*;
#(
    parameter int PROG_CYCLES   = 20,
    parameter int ERASE_CYCLES  = 60,
    parameter int SETTLE_CYCLES = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       op_erase_i,
    input  logic [7:0] prog_byte_i,
    input  logic [7:0] array_data_i,
    input  logic       rd_strobe_i,
    input  logic       addr_valid_i,
    output logic [7:0] rd_data_o,
    output logic       busy_o
);
    phase_e phase;
    op_t    op;
    logic   accept;
    logic   tog;

    flash_stat_seq #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES),
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .erase_i (op_erase_i),
        .target_i(prog_byte_i),
        .phase_o (phase),
        .op_o    (op),
        .accept_o(accept)
    );

    flash_stat_toggle tog_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (accept),
        .busy_i  (phase == PH_BUSY),
        .strobe_i(rd_strobe_i),
        .valid_i (addr_valid_i),
        .tog_o   (tog)
    );

    flash_stat_mux mux_i (
        .phase_i(phase),
        .op_i   (op),
        .tog_i  (tog),
        .valid_i(addr_valid_i),
        .array_i(array_data_i),
        .data_o (rd_data_o)
    );

    assign busy_o = (phase == PH_BUSY);

    // R2
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R8
    settle_fill_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_o) && addr_valid_i) |-> (rd_data_o[6:0] == 7'h7F));

endmodule

// File: tb/flash_stat_resp_tb_top.sv
module flash_stat_resp_tb_top;
    localparam int PC = 5;
    localparam int EC = 9;
    localparam int SC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       erase = 1'b0;
    logic [7:0] pbyte = 8'h00;
    logic [7:0] arr = 8'h00;
    logic       strobe = 1'b0;
    logic       valid = 1'b1;
    logic [7:0] rdata;
    logic       busy;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    flash_stat_resp #(
        .PROG_CYCLES  (PC),
        .ERASE_CYCLES (EC),
        .SETTLE_CYCLES(SC)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .op_erase_i  (erase),
        .prog_byte_i (pbyte),
        .array_data_i(arr),
        .rd_strobe_i (strobe),
        .addr_valid_i(valid),
        .rd_data_o   (rdata),
        .busy_o      (busy)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic run_op(input logic er, input logic [7:0] b, input int pat, input bit restart);
        int         dur = er ? EC : PC;
        logic       tog = 1'b0;
        logic       prev_s = 1'b0;
        logic       cur_v = 1'b1;
        logic [7:0] cur_a;
        logic [7:0] exp;
        string      tag;
        @(negedge clk);
        start = 1'b1; erase = er; pbyte = b; strobe = 1'b0; valid = 1'b1;
        cur_a = arr;
        for (int i = 1; i <= dur + SC + 2; i++) begin
            @(negedge clk);
            if (!cur_v) begin
                exp = 8'h00; tag = "R10 invalid address";
            end else if (i <= dur) begin
                exp = {er ? 1'b0 : ~b[7], tog, 6'h3F};
                tag = er ? "R5 R6 R7 erase busy" : "R4 R6 R7 program busy";
            end else if (i <= dur + SC) begin
                exp = {er ? 1'b1 : b[7], 7'h7F}; tag = "R8 settle";
            end else begin
                exp = cur_a; tag = "R9 idle passthrough";
            end
            chk(tag, rdata, exp);
            chk("R2 R3 busy length", {7'd0, busy}, {7'd0, (i <= dur)});
            start = restart && (i == 2);
            if (start) begin
                erase = ~er; pbyte = ~b;
            end
            case (pat)
                0: strobe = i[0];
                1: strobe = i[1];
                2: strobe = 1'b1;
                default: strobe = i[0];
            endcase
            valid = (pat == 3) ? ((i % 3) != 0) : 1'b1;
            arr = 8'(i * 53 + int'(b));
            if (i <= dur && prev_s && !strobe && valid) tog = ~tog;
            prev_s = strobe;
            cur_v = valid;
            cur_a = arr;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        arr = 8'hA5;
        valid = 1'b1;
        @(negedge clk);
        chk("R1 reset read", rdata, 8'hA5);
        chk("R1 reset busy", {7'd0, busy}, 8'h00);
        valid = 1'b0;
        @(negedge clk);
        chk("R10 invalid at idle", rdata, 8'h00);
        valid = 1'b1;
        for (int b = 0; b < 256; b++) begin
            run_op(1'b0, 8'(b), b % 4, (b % 16) == 5);
        end
        for (int b = 0; b < 16; b++) begin
            run_op(1'b1, 8'(b * 17), b % 4, (b % 8) == 3);
        end
        summary();
        $finish;
    end
endmodule